// File: doc/BRIEF.md
# Serial Character Transmitter with In-Band Pause

This block turns parallel characters into an asynchronous serial stream on one output line. Each character is framed with a low start bit, a data field of five to nine bits sent least significant bit first, an optional parity bit and one or two high stop bits. The frame shape comes from configuration inputs and is captured when a character is accepted, so the inputs may change while a frame is on the line.

Characters arrive on a valid/ready handshake. An external divider supplies a single-cycle enable pulse at the bit rate, and the line moves only on those pulses. A companion receiver reports each incoming byte with a strobe. When software flow control is on, a received pause code (19) stops new characters from starting and a received resume code (17) allows them again. A character that is already on the line always finishes its whole frame.

Top module: `flow_gated_uart_tx`

## Requirements
- R1: After reset `txLine` is high and `txReady` is high. `txReady` is only high while the line is idle and high.
- R2: A frame is one low start bit followed by N data bits from `txData`, bit 0 first. N is `cfgDataBits` (5 to 9; below 5 counts as 5, above 9 counts as 9). Bits of `txData` at or above N are never sent. The configuration is captured in the cycle the character is accepted.
- R3: `cfgParity` = 2'b01 selects even parity and 2'b10 selects odd parity. 2'b00 and 2'b11 give no parity bit. The parity bit follows the last data bit and makes the count of ones over the data and parity bits even or odd as selected.
- R4: With 9 data bits no parity bit is sent, whatever `cfgParity` holds.
- R5: `cfgTwoStop` = 0 gives one high stop bit and 1 gives two.
- R6: While `cfgFlowEn` is high, a received byte of 19 pauses the block: `txReady` goes low in the next cycle and no start bit begins. A received 17 resumes it.
- R7: A pause code received during a frame lets that frame finish with all its bits. The next start bit is held back.
- R8: The pause state is "resumed" after reset. While `cfgFlowEn` is low, received bytes neither gate transmission nor change the stored pause state.
- R9: `txReady` falls in the cycle after a character is accepted. It rises again only when the last stop-bit period ends.
- R10: `txLine` changes only at a clock edge where `bitTick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | Single-cycle enable pulse at the bit rate |
| txData | input | 9 | Character to send, bit 0 first |
| txValid | input | 1 | Character on txData is offered |
| txReady | output | 1 | Block can accept a character |
| rxStrobe | input | 1 | A received byte is present this cycle |
| rxByte | input | 8 | Value of the received byte |
| cfgDataBits | input | 4 | Data field length, 5 to 9 |
| cfgParity | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| cfgTwoStop | input | 1 | 1 selects two stop bits |
| cfgFlowEn | input | 1 | Enables in-band pause/resume |
| txLine | output | 1 | Serial output, idles high |

## Verification
The checker watches on every cycle that the line changes only on tick edges, that ready implies an idle high line, that ready drops right after each handshake and falls for no other reason, and that a pause code with flow control on blocks the handshake in the next cycle. Only the bench scenarios can show the frame contents: bit order, how the width masks the data, the parity value for each mode, parity being suppressed at nine bits, the number of stop bits, a frame finishing through a mid-frame pause, and pause codes having no effect while flow control is off.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int MIN_BITS = 5;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF  = 2'b11
  } parMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic goStart;
    logic goData;
    logic goPar;
    logic goStop;
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_dpath.sv
module uart_tx_dpath
  import uart_tx_pkg::*;
#(
  parameter int DATA_MAX = 9,
  parameter int CNT_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           strobe,
  input  logic [DATA_MAX-1:0] txData,
  input  logic [CNT_W-1:0]    cfgDataBits,
  input  logic [1:0]          cfgParity,
  input  logic                cfgTwoStop,
  output logic [CNT_W-1:0]    frameBits,
  output logic                parityOn,
  output logic                twoStop,
  output logic                txLine
);

  localparam logic [CNT_W-1:0] LO_BITS = CNT_W'(MIN_BITS);
  localparam logic [CNT_W-1:0] HI_BITS = CNT_W'(DATA_MAX);

  logic [CNT_W-1:0]    useBits;
  logic [DATA_MAX-1:0] dataMask;
  logic                parNext;
  logic                parOnNext;
  logic [DATA_MAX-1:0] shReg;
  logic                parQ;

  always_comb begin
    if (cfgDataBits < LO_BITS)      useBits = LO_BITS;
    else if (cfgDataBits > HI_BITS) useBits = HI_BITS;
    else                            useBits = cfgDataBits;
  end

  for (genvar i = 0; i < DATA_MAX; i++) begin : g_mask
    assign dataMask[i] = (CNT_W'(i) < useBits);
  end

  assign parOnNext = ((cfgParity == PAR_EVEN) || (cfgParity == PAR_ODD)) &&
                     (useBits != HI_BITS);
  assign parNext   = (^(txData & dataMask)) ^ (cfgParity == PAR_ODD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      parQ      <= 1'b0;
      frameBits <= LO_BITS;
      parityOn  <= 1'b0;
      twoStop   <= 1'b0;
      txLine    <= 1'b1;
    end else begin
      if (strobe.load) begin
        shReg     <= txData & dataMask;
        parQ      <= parNext;
        frameBits <= useBits;
        parityOn  <= parOnNext;
        twoStop   <= cfgTwoStop;
      end
      if (strobe.goStart) txLine <= 1'b0;
      if (strobe.goData) begin
        txLine <= shReg[0];
        shReg  <= shReg >> 1;
      end
      if (strobe.goPar)  txLine <= parQ;
      if (strobe.goStop) txLine <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int CODE_W    = 8,
  parameter int XOFF_CODE = 19,
  parameter int XON_CODE  = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              txValid,
  output logic              txReady,
  input  logic              rxStrobe,
  input  logic [CODE_W-1:0] rxByte,
  input  logic              cfgFlowEn,
  input  logic [CNT_W-1:0]  frameBits,
  input  logic              parityOn,
  input  logic              twoStop,
  output txStrobe_t         strobe
);

  localparam logic [CODE_W-1:0] OFF_C = CODE_W'(XOFF_CODE);
  localparam logic [CODE_W-1:0] ON_C  = CODE_W'(XON_CODE);

  txState_e         state;
  logic [CNT_W-1:0] bitCnt;
  logic             stopSecond;
  logic             pausedQ;
  logic             pauseEff;
  logic             lastData;

  assign pauseEff = pausedQ && cfgFlowEn;
  assign txReady  = (state == ST_IDLE) && !pauseEff;
  assign lastData = (bitCnt == frameBits);

  always_comb begin
    strobe      = '0;
    strobe.load = txValid && txReady;
    if (bitTick) begin
      unique case (state)
        ST_WAIT:  strobe.goStart = !pauseEff;
        ST_START: strobe.goData  = 1'b1;
        ST_DATA: begin
          if (!lastData)     strobe.goData = 1'b1;
          else if (parityOn) strobe.goPar  = 1'b1;
          else               strobe.goStop = 1'b1;
        end
        ST_PAR:   strobe.goStop = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pausedQ <= 1'b0;
    end else if (rxStrobe && cfgFlowEn) begin
      if (rxByte == OFF_C)     pausedQ <= 1'b1;
      else if (rxByte == ON_C) pausedQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      stopSecond <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:  if (strobe.load) state <= ST_WAIT;
        ST_WAIT:  if (strobe.goStart) state <= ST_START;
        ST_START: if (bitTick) begin
          state  <= ST_DATA;
          bitCnt <= CNT_W'(1);
        end
        ST_DATA:  if (bitTick) begin
          if (!lastData) bitCnt <= bitCnt + 1'b1;
          else if (parityOn) state <= ST_PAR;
          else begin
            state      <= ST_STOP;
            stopSecond <= 1'b0;
          end
        end
        ST_PAR:   if (bitTick) begin
          state      <= ST_STOP;
          stopSecond <= 1'b0;
        end
        ST_STOP:  if (bitTick) begin
          if (twoStop && !stopSecond) stopSecond <= 1'b1;
          else                        state      <= ST_IDLE;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flow_gated_uart_tx.sv
module flow_gated_uart_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_MAX  = 9,
  parameter int CODE_W    = 8,
  parameter int XOFF_CODE = 19,
  parameter int XON_CODE  = 17
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        bitTick,
  input  logic [DATA_MAX-1:0]         txData,
  input  logic                        txValid,
  output logic                        txReady,
  input  logic                        rxStrobe,
  input  logic [CODE_W-1:0]           rxByte,
  input  logic [$clog2(DATA_MAX+1)-1:0] cfgDataBits,
  input  logic [1:0]                  cfgParity,
  input  logic                        cfgTwoStop,
  input  logic                        cfgFlowEn,
  output logic                        txLine
);

  localparam int CNT_W = $clog2(DATA_MAX + 1);

  txStrobe_t        strobe;
  logic [CNT_W-1:0] frameBits;
  logic             parityOn;
  logic             twoStop;

  uart_tx_ctrl #(
    .CNT_W(CNT_W), .CODE_W(CODE_W),
    .XOFF_CODE(XOFF_CODE), .XON_CODE(XON_CODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .txValid(txValid), .txReady(txReady),
    .rxStrobe(rxStrobe), .rxByte(rxByte), .cfgFlowEn(cfgFlowEn),
    .frameBits(frameBits), .parityOn(parityOn), .twoStop(twoStop),
    .strobe(strobe)
  );

  uart_tx_dpath #(.DATA_MAX(DATA_MAX), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txData(txData), .cfgDataBits(cfgDataBits),
    .cfgParity(cfgParity), .cfgTwoStop(cfgTwoStop),
    .frameBits(frameBits), .parityOn(parityOn), .twoStop(twoStop),
    .txLine(txLine)
  );

endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk #(
  parameter int CODE_W    = 8,
  parameter int XOFF_CODE = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              bitTick,
  input logic              txValid,
  input logic              txReady,
  input logic              rxStrobe,
  input logic [CODE_W-1:0] rxByte,
  input logic              cfgFlowEn,
  input logic              txLine
);

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine);

  // R9
  ready_drops_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  // R9
  ready_falls_only_on_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txReady) |-> ($past(txValid) || $past(cfgFlowEn)));

  // R10
  line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(txLine));

  // R6
  pause_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFlowEn && rxStrobe && rxByte == CODE_W'(XOFF_CODE)) |=> (!txReady || !cfgFlowEn));

endmodule

bind flow_gated_uart_tx uart_tx_chk #(.CODE_W(CODE_W), .XOFF_CODE(XOFF_CODE)) u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .txValid(txValid),
  .txReady(txReady), .rxStrobe(rxStrobe), .rxByte(rxByte),
  .cfgFlowEn(cfgFlowEn), .txLine(txLine)
);

// File: tb/sim_flow_gated_uart_tx.sv
`timescale 1ns/1ps
module sim_flow_gated_uart_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick;
  logic [8:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txReady;
  logic       rxStrobe = 1'b0;
  logic [7:0] rxByte = '0;
  logic [3:0] cfgDataBits = 4'd8;
  logic [1:0] cfgParity = 2'b00;
  logic       cfgTwoStop = 1'b0;
  logic       cfgFlowEn = 1'b0;
  logic       txLine;
  logic [1:0] tickCnt = '0;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) tickCnt <= '0;
    else       tickCnt <= tickCnt + 2'd1;
  end
  assign bitTick = (tickCnt == 2'd3);

  flow_gated_uart_tx u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxStrobe(rxStrobe), .rxByte(rxByte),
    .cfgDataBits(cfgDataBits), .cfgParity(cfgParity),
    .cfgTwoStop(cfgTwoStop), .cfgFlowEn(cfgFlowEn),
    .txLine(txLine)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishAll();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    finishAll();
  end

  task automatic nextBit();
    while (!bitTick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulseRx(input logic [7:0] b);
    rxByte   = b;
    rxStrobe = 1'b1;
    @(negedge clk);
    rxStrobe = 1'b0;
  endtask

  task automatic offerChar(input logic [8:0] d, input int bits,
                           input logic [1:0] par, input logic two);
    txData      = d;
    cfgDataBits = 4'(bits);
    cfgParity   = par;
    cfgTwoStop  = two;
    txValid     = 1'b1;
  endtask

  // wait for handshake while valid held, then drop valid
  task automatic acceptChar(input string req);
    int n = 0;
    while (!txReady && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(req, int'(txReady), 1);
    @(negedge clk);
    txValid = 1'b0;
    check(req, int'(txReady), 0);
  endtask

  // capture and compare a full frame; optionally receive a byte after bit injAt
  task automatic captureFrame(input string req, input logic [8:0] d, input int bits,
                              input logic [1:0] par, input logic two,
                              input int injAt, input logic [7:0] injByte);
    int n = 0;
    int eb;
    logic [8:0] md;
    logic parOn, pbit;
    md = '0;
    for (int i = 0; i < bits; i++) md[i] = d[i];
    parOn = ((par == 2'b01) || (par == 2'b10)) && (bits != 9);
    pbit  = (^md) ^ (par == 2'b10);
    while (txLine && n < 400) begin
      @(negedge clk);
      n++;
    end
    check({req, " start"}, int'(txLine), 0);
    for (int i = 0; i < bits; i++) begin
      if (i == injAt) pulseRx(injByte);
      nextBit();
      eb = int'(md[i]);
      check({req, " data"}, int'(txLine), eb);
      check({req, " R9 busy"}, int'(txReady), 0);
    end
    if (parOn) begin
      nextBit();
      check({req, " parity"}, int'(txLine), int'(pbit));
    end
    nextBit();
    check({req, " stop1"}, int'(txLine), 1);
    check({req, " R9 busy in stop"}, int'(txReady), 0);
    if (two) begin
      nextBit();
      check({req, " stop2"}, int'(txLine), 1);
      check({req, " R9 busy in stop2"}, int'(txReady), 0);
    end
    nextBit();
    check({req, " line idle"}, int'(txLine), 1);
  endtask

  task automatic sendFrame(input string req, input logic [8:0] d, input int bits,
                           input logic [1:0] par, input logic two);
    offerChar(d, bits, par, two);
    acceptChar({req, " R9 accept"});
    captureFrame(req, d, bits, par, two, -1, 8'h00);
    check({req, " R9 ready back"}, int'(txReady), 1);
  endtask

  task automatic testReset();
    check("R1 reset line", int'(txLine), 1);
    check("R1 reset ready", int'(txReady), 1);
  endtask

  task automatic testBasic();
    sendFrame("R2 8N1", 9'h0A5, 8, 2'b00, 1'b0);
    sendFrame("R2 5-bit masked R3 even", 9'h1FB, 5, 2'b01, 1'b0);
    sendFrame("R3 odd 7-bit R5 two stop", 9'h055, 7, 2'b10, 1'b1);
    sendFrame("R3 code 11 none", 9'h033, 6, 2'b11, 1'b0);
  endtask

  task automatic testNineBit();
    sendFrame("R4 9-bit even suppressed", 9'h1C3, 9, 2'b01, 1'b0);
    sendFrame("R4 9-bit odd suppressed R5", 9'h101, 9, 2'b10, 1'b1);
  endtask

  task automatic holdPaused(input string req);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(req, int'(txLine), 1);
      check(req, int'(txReady), 0);
    end
  endtask

  task automatic testPause();
    cfgFlowEn = 1'b1;
    pulseRx(8'd19);
    check("R6 paused ready", int'(txReady), 0);
    offerChar(9'h03C, 8, 2'b00, 1'b0);
    holdPaused("R6 held");
    pulseRx(8'd17);
    acceptChar("R6 resume");
    captureFrame("R6 after resume", 9'h03C, 8, 2'b00, 1'b0, -1, 8'h00);
  endtask

  task automatic testMidFrame();
    offerChar(9'h0C9, 8, 2'b01, 1'b0);
    acceptChar("R7 accept");
    captureFrame("R7 frame finishes", 9'h0C9, 8, 2'b01, 1'b0, 2, 8'd19);
    offerChar(9'h011, 8, 2'b00, 1'b0);
    holdPaused("R7 next held");
    pulseRx(8'd17);
    acceptChar("R7 resume");
    captureFrame("R7 next frame", 9'h011, 8, 2'b00, 1'b0, -1, 8'h00);
  endtask

  task automatic testFlowOff();
    cfgFlowEn = 1'b0;
    pulseRx(8'd19);
    check("R8 off ignores pause", int'(txReady), 1);
    sendFrame("R8 sends while off", 9'h07E, 8, 2'b00, 1'b0);
    cfgFlowEn = 1'b1;
    @(negedge clk);
    check("R8 state untouched", int'(txReady), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testNineBit();
    testPause();
    testMidFrame();
    testFlowOff();
    repeat (5) @(negedge clk);
    finishAll();
  end

endmodule